// File: doc/BRIEF.md
# USB Error Interrupt Controller

This block turns error events reported by a USB packet engine into sticky interrupt requests and drives one interrupt line. It watches four isochronous OUT endpoints (numbers 2, 4, 6 and 8). An endpoint's request is raised by a data PID sequence error, but only at high speed. It is also raised by a packet dropped for lack of buffer space, at either speed. A second source counts general bus errors, such as CRC and bit-stuff failures. It raises its request when the running count reaches a programmable limit between 0 and 15.

Software sees three 8-bit registers on a plain write/read port: an enable mask, the request flags, and the error limit. Request flags are cleared by writing ones; zeros written leave flags alone, so a mask write clears only the chosen requests. Reads are combinational on `rd_addr`. Writes take effect on the clock edge where `wr_en` is high. No data stream crosses the block, so there is no valid/ready handshake and no back-pressure: every strobe and every write is taken in the cycle it is presented. Detecting errors on the wire is left to the packet engine.

Top module: `usb_err_irq_ctrl`

## Requirements
- R1: After reset the enable, request and limit registers read 0 and `irq` is low.
- R2: Enable and request share one layout. Bit 4+i belongs to ISO input index i (endpoints 2, 4, 6, 8 for i = 0..3), and bit 0 is the error-limit flag. Bits 3..1 ignore writes and always read 0.
- R3: A pulse on `iso_seq_err[i]` sets request bit 4+i only when `high_speed` is 1 in that cycle.
- R4: A pulse on `iso_drop[i]` sets request bit 4+i whatever the value of `high_speed`.
- R5: Each `bus_err` pulse adds one to an error count. Request bit 0 is set on the pulse that brings the count to the limit. With limit 0, any bus error sets it.
- R6: The count saturates at the limit and is returned to zero when software writes 1 to request bit 0.
- R7: Writing address 1 clears each request bit written as 1 and leaves bits written as 0 unchanged. Flags otherwise stay set.
- R8: When an event and a clear reach the same request bit in one cycle, the bit ends up set.
- R9: `irq` is high exactly when some request bit has its enable bit set. Clearing an enable masks `irq` but keeps the request pending.
- R10: Register addresses are 0 enable, 1 request, 2 limit. The limit is held in bits 3..0 of address 2; its upper bits read 0. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data, combinational |
| iso_seq_err | input | 4 | Per-endpoint PID sequence error strobes |
| iso_drop | input | 4 | Per-endpoint no-buffer drop strobes |
| high_speed | input | 1 | Link is running at high speed |
| bus_err | input | 1 | Bus error strobe |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is the same-cycle collision: a software clear and a new event hitting the same request bit. For the error-limit bit, the collision also involves the counter reset and an increment together. Directed steps line up a request write with a drop strobe. They also line up a bit-0 clear with a bus error at limits 0 and 5. A long run of random strobes and writes then collides them repeatedly, while a behavioural model checks the read port and `irq` on every clock.

// File: rtl/usb_err_pkg.sv
package usb_err_pkg;
  localparam int REG_W      = 8;
  localparam int NUM_ISO_EP = 4;
  localparam int CNT_W      = 4;
  localparam int LIMIT_BIT  = 0;

  typedef enum logic [1:0] {
    ADDR_ENABLE  = 2'd0,
    ADDR_REQUEST = 2'd1,
    ADDR_LIMIT   = 2'd2,
    ADDR_NONE    = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/usb_err_iso_flag.sv
module usb_err_iso_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic seq_err,
  input  logic drop,
  input  logic high_speed,
  input  logic clr,
  output logic flag
);
  logic set_evt;

  // sequence errors only count at high speed; drops count at any speed
  assign set_evt = drop | (seq_err & high_speed);

  always_ff @(posedge clk) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= set_evt | (flag & ~clr);
  end

  assert_drop_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> flag);
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_err && high_speed && clr) |=> flag);
  assert_fs_seq_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && seq_err && !high_speed && !drop) |=> !flag);
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
endmodule

// File: rtl/usb_err_limit_counter.sv
module usb_err_limit_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_err,
  input  logic             clr,
  input  logic [CNT_W-1:0] limit,
  output logic             flag
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] base;
  logic [CNT_W:0]   inc;
  logic             hit;

  // a software clear restarts the count before this cycle's error is added
  assign base = clr ? '0 : cnt_q;
  assign inc  = {1'b0, base} + {{CNT_W{1'b0}}, 1'b1};
  assign hit  = bus_err && (inc >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      flag  <= 1'b0;
    end else begin
      if (bus_err) cnt_q <= hit ? limit : inc[CNT_W-1:0];
      else         cnt_q <= base;
      flag <= hit | (flag & ~clr);
    end
  end

  assert_cnt_saturates_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> (cnt_q <= $past(limit)));
  assert_clear_restarts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !bus_err) |=> (cnt_q == '0));
  assert_flag_needs_error_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !bus_err) |=> !flag);
  assert_zero_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err && limit == '0) |=> flag);
endmodule

// File: rtl/usb_err_irq_ctrl.sv
module usb_err_irq_ctrl
  import usb_err_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [REG_W-1:0] rd_data,
  input  logic [NUM_ISO_EP-1:0] iso_seq_err,
  input  logic [NUM_ISO_EP-1:0] iso_drop,
  input  logic             high_speed,
  input  logic             bus_err,
  output logic             irq
);
  localparam int ISO_LSB = REG_W - NUM_ISO_EP;

  logic [REG_W-1:0]      valid_mask;
  logic [REG_W-1:0]      en_q;
  logic [REG_W-1:0]      req_vec;
  logic [REG_W-1:0]      clr_vec;
  logic [CNT_W-1:0]      limit_q;
  logic [NUM_ISO_EP-1:0] iso_flag;
  logic                  lim_flag;
  logic                  wr_en_reg, wr_req, wr_lim;

  always_comb begin
    valid_mask = '0;
    valid_mask[LIMIT_BIT] = 1'b1;
    for (int i = 0; i < NUM_ISO_EP; i++) valid_mask[ISO_LSB+i] = 1'b1;
  end

  assign wr_en_reg = wr_en && (wr_addr == ADDR_ENABLE);
  assign wr_req    = wr_en && (wr_addr == ADDR_REQUEST);
  assign wr_lim    = wr_en && (wr_addr == ADDR_LIMIT);
  assign clr_vec   = wr_req ? (wr_data & valid_mask) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= '0;
      limit_q <= '0;
    end else begin
      if (wr_en_reg) en_q    <= wr_data & valid_mask;
      if (wr_lim)    limit_q <= wr_data[CNT_W-1:0];
    end
  end

  for (genvar g = 0; g < NUM_ISO_EP; g++) begin : g_iso
    usb_err_iso_flag i_flag (
      .clk        (clk),
      .rst_n      (rst_n),
      .seq_err    (iso_seq_err[g]),
      .drop       (iso_drop[g]),
      .high_speed (high_speed),
      .clr        (clr_vec[ISO_LSB+g]),
      .flag       (iso_flag[g])
    );
  end

  usb_err_limit_counter #(.CNT_W(CNT_W)) i_limit (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_err (bus_err),
    .clr     (clr_vec[LIMIT_BIT]),
    .limit   (limit_q),
    .flag    (lim_flag)
  );

  always_comb begin
    req_vec = '0;
    req_vec[LIMIT_BIT] = lim_flag;
    for (int i = 0; i < NUM_ISO_EP; i++) req_vec[ISO_LSB+i] = iso_flag[i];
  end

  always_comb begin
    unique case (rd_addr)
      ADDR_ENABLE:  rd_data = en_q;
      ADDR_REQUEST: rd_data = req_vec;
      ADDR_LIMIT:   rd_data = {{(REG_W-CNT_W){1'b0}}, limit_q};
      default:      rd_data = '0;
    endcase
  end

  assign irq = |(req_vec & en_q);

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr != ADDR_LIMIT) |-> (rd_data[ISO_LSB-1:1] == '0));
  assert_limit_upper_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == ADDR_LIMIT) |-> (rd_data[REG_W-1:CNT_W] == '0));
  assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_reg && wr_data == '0) |=> !irq);
  assert_mask_keeps_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_reg && !wr_req && iso_flag[0]) |=> iso_flag[0]);
endmodule

// File: tb/test_usb_err_irq_ctrl.sv
module test_usb_err_irq_ctrl;
  localparam int PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 200000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [3:0] iso_seq_err = '0;
  logic [3:0] iso_drop = '0;
  logic       high_speed = 1'b0;
  logic       bus_err = 1'b0;
  logic       irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  // behavioural reference state
  int m_en = 0, m_req = 0, m_lim = 0, m_cnt = 0;

  always #(PERIOD/2) clk = ~clk;

  usb_err_irq_ctrl i_usb_err_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .iso_seq_err(iso_seq_err), .iso_drop(iso_drop),
    .high_speed(high_speed), .bus_err(bus_err), .irq(irq)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles >= WATCHDOG_CYCLES && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: run did not end, actual %0d cycles expected fewer", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic int model_read(int a);
    case (a)
      0: return m_en;
      1: return m_req;
      2: return m_lim;
      default: return 0;
    endcase
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // model update for one clock edge, following the requirements
  task automatic model_edge(bit we, int wa, int wd, int sq, int dp, bit hs, bit be);
    int clr, set, base;
    clr = (we && wa == 1) ? (wd & 'hF1) : 0;        // R7, R2
    set = 0;
    for (int i = 0; i < 4; i++)
      if (dp[i] || (sq[i] && hs)) set |= (1 << (4 + i));   // R3, R4
    base = clr[0] ? 0 : m_cnt;                            // R6
    if (be) begin
      if (base + 1 >= m_lim) begin set |= 1; m_cnt = m_lim; end  // R5
      else m_cnt = base + 1;
    end else m_cnt = base;
    m_req = (m_req & ~clr) | set;                         // R8: set wins
    if (we && wa == 0) m_en = wd & 'hF1;
    if (we && wa == 2) m_lim = wd & 'hF;                  // R10
  endtask

  task automatic step(string tag, bit we, int wa, int wd, int sq, int dp,
                      bit hs, bit be, int ra);
    wr_en = we; wr_addr = wa[1:0]; wr_data = wd[7:0];
    iso_seq_err = sq[3:0]; iso_drop = dp[3:0];
    high_speed = hs; bus_err = be; rd_addr = ra[1:0];
    @(posedge clk);
    model_edge(we, wa, wd, sq, dp, hs, be);
    @(negedge clk);
    check(tag, "rd_data", int'(rd_data), model_read(ra));
    check(tag, "irq", int'(irq), ((m_req & m_en) != 0) ? 1 : 0);  // R9
  endtask

  task automatic idle_read(string tag, int ra);
    step(tag, 0, 0, 0, 0, 0, 0, 0, ra);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    idle_read("R1", 0);
    idle_read("R1", 1);
    idle_read("R1", 2);
    idle_read("R10", 3);
    // R3: sequence error ignored at full speed, taken at high speed
    step("R3", 0, 0, 0, 'b0001, 0, 0, 0, 1);
    step("R3", 0, 0, 0, 'b0001, 0, 1, 0, 1);
    // R4: drop sets at full speed and at high speed
    step("R4", 0, 0, 0, 0, 'b1000, 0, 0, 1);
    step("R4", 0, 0, 0, 0, 'b0100, 1, 0, 1);
    // R7: clear only bit 4
    step("R7", 1, 1, 'h10, 0, 0, 0, 0, 1);
    // R2: reserved bits ignore writes
    step("R2", 1, 0, 'hFF, 0, 0, 0, 0, 0);
    step("R2", 1, 1, 'h0E, 0, 0, 0, 0, 1);
    // R9: mask the interrupt, request stays pending
    step("R9", 1, 0, 'h00, 0, 0, 0, 0, 1);
    step("R9", 1, 0, 'h80, 0, 0, 0, 0, 1);
    step("R7", 1, 1, 'hC0, 0, 0, 0, 0, 1);
    // R5, R10: limit 3, third error raises bit 0
    step("R10", 1, 2, 'hF3, 0, 0, 0, 0, 2);
    step("R5", 1, 0, 'h01, 0, 0, 0, 1, 1);
    step("R5", 0, 0, 0, 0, 0, 0, 1, 1);
    step("R5", 0, 0, 0, 0, 0, 0, 1, 1);
    // R6: saturation, then clear restarts the count at limit 5
    step("R6", 1, 2, 'h05, 0, 0, 0, 1, 1);
    step("R6", 1, 1, 'h01, 0, 0, 0, 0, 1);
    for (int k = 0; k < 5; k++) step("R6", 0, 0, 0, 0, 0, 0, 1, 1);
    // R8: clear plus error in one cycle with limit 5
    step("R8", 1, 1, 'h01, 0, 0, 0, 1, 1);
    // R5: limit 0, any error sets
    step("R5", 1, 2, 'h00, 0, 0, 0, 0, 2);
    step("R5", 0, 0, 0, 0, 0, 0, 1, 1);
    // R8: clear and event on the same bit
    step("R8", 1, 1, 'h21, 0, 'b0010, 0, 1, 1);
    step("R8", 1, 1, 'h80, 'b1000, 0, 1, 0, 1);
    // random collisions of writes and strobes
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom;
      step("R9", (r[3:0] < 5), r[5:4] % 3, $urandom % 256,
           (r[9:6] & $urandom), (r[13:10] & $urandom & $urandom),
           r[14], r[15] & r[16], r[18:17]);
    end
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule